// File: doc/BRIEF.md
# Paged Address Translator with Tagged Lookaside Cache

This block turns a virtual address from a processor into a physical address for a memory laid out as one level of fixed-size pages. The low bits of the virtual address are the page offset and go through unchanged. The upper bits are the page number. A small fully associative lookaside cache is searched first. Each of its entries is tagged with an address-space identifier, so translations from different processes can be held at the same time.

When the cache misses, the page number is first checked against a table-length input. A page number inside the table starts a walk: one read of the page-table entry through a single memory read port. A valid entry refills the cache and completes the translation. An out-of-range page number or an invalid entry returns a fault with a cause code, and nothing is cached.

Software-side control consists of two invalidation inputs: one clears every entry, the other clears only the entries of a chosen identifier.

Top module: `page_xlate`

## Requirements
- R1: The low PAGE_BITS (default 12) bits of `req_vaddr` are the offset and the upper bits are the page number. A successful `rsp_paddr` is the frame number joined above the unchanged offset.
- R2: When a valid cache entry matches both the page number and `req_asid`, the response appears in the cycle after the request is accepted, and no memory read is issued.
- R3: An entry whose page number matches but whose identifier differs is a miss. At most one entry ever matches a lookup.
- R4: On a miss with the page number in range, exactly one memory read is issued, at byte address `pt_base + 4*page_number`. The response is given only after the read data returns.
- R5: Page-table entries are PA_W bits wide. Bit 0 is the valid flag, and bits [PA_W-1:PAGE_BITS] hold the frame number. A valid entry is written into the cache and used for the response.
- R6: On a miss where the page number is greater than or equal to `pt_len`, no memory read is issued, and the response has `rsp_fault`=1 and `rsp_cause`=1.
- R7: An invalid page-table entry gives `rsp_fault`=1 and `rsp_cause`=2. The entry is not cached, so the next access to the same page reads memory again.
- R8: On success, `rsp_fault`=0 and `rsp_cause`=0. On any fault, `rsp_paddr` is zero.
- R9: `req_ready` is low for the whole time a walk is in progress. The memory request holds its address steady until `mem_req_ready` accepts it.
- R10: `flush_all` invalidates every entry. It takes priority over a refill in the same cycle.
- R11: `flush_asid` invalidates only the entries whose identifier equals `flush_id`. Entries of other identifiers keep hitting.
- R12: Refills go to slots in round-robin order. After eight fills, a ninth distinct page replaces the oldest fill, and the remaining seven still hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | VA_W | Virtual address |
| req_asid | input | ASID_W | Identifier of the requesting address space |
| rsp_valid | output | 1 | Response valid for one cycle |
| rsp_paddr | output | PA_W | Physical address (zero on fault) |
| rsp_fault | output | 1 | Translation failed |
| rsp_cause | output | 2 | 0 none, 1 page beyond table length, 2 invalid entry |
| pt_base | input | PA_W | Byte address of the page table |
| pt_len | input | VA_W-PAGE_BITS+1 | Number of entries in the page table |
| flush_all | input | 1 | Invalidate all cache entries |
| flush_asid | input | 1 | Invalidate entries of identifier `flush_id` |
| flush_id | input | ASID_W | Identifier for selective invalidation |
| mem_req_valid | output | 1 | Page-table read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | PA_W | Page-table entry byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | PA_W | Page-table entry read back |

## Verification
A corrupted cache slot shows up at the next request for that page: a wrong frame in `rsp_paddr` one cycle after acceptance, or a read on the memory port where none was due. A walker stuck in the wrong state shows within one request as `req_ready` staying low or a missing response. A replacement pointer that drifts only shows after a full set of eight fills, when the wrong page starts missing. The bench counts memory reads per request so that hit and miss paths can be told apart.

// File: rtl/xlate_pkg.sv
// Shared definitions for the paged address translator.
// Assumes: fault cause codes are a 2-bit field visible at the top ports.
package xlate_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'd0,
        CAUSE_RANGE   = 2'd1,
        CAUSE_INVALID = 2'd2
    } cause_e;

    typedef enum logic [1:0] {
        W_IDLE = 2'd0,
        W_REQ  = 2'd1,
        W_WAIT = 2'd2
    } walk_state_e;

endpackage

// File: rtl/xlate_tlb.sv
// Fully associative translation cache with identifier tags.
// Does: parallel compare of page number and identifier, round-robin refill,
//       global and per-identifier invalidation.
// Assumes: a refill is only requested for a page that missed, so tags stay unique.
module xlate_tlb #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    parameter int ASID_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              lk_hit,
    output logic [PFN_W-1:0]  lk_pfn,
    input  logic              fill_en,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic              flush_all,
    input  logic              flush_asid,
    input  logic [ASID_W-1:0] flush_id
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    logic [ENTRIES-1:0] valid_q;
    logic [ENTRIES-1:0] match;
    logic [VPN_W-1:0]   vpn_q  [ENTRIES];
    logic [ASID_W-1:0]  asid_q [ENTRIES];
    logic [PFN_W-1:0]   pfn_q  [ENTRIES];
    logic [IDX_W-1:0]   victim_q;
    logic               fill_keep;

    // Per-entry tag comparators, all in parallel
    generate
        for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
            assign match[i] = valid_q[i] && (vpn_q[i] == lk_vpn) && (asid_q[i] == lk_asid);
        end
    endgenerate

    assign lk_hit = |match;

    // Select the frame of the single matching entry
    always_comb begin
        lk_pfn = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) lk_pfn = lk_pfn | pfn_q[i];
        end
    end

    // A refill survives only if no same-cycle flush would remove it
    assign fill_keep = fill_en && !flush_all && !(flush_asid && (fill_asid == flush_id));

    // Entry storage, invalidation and round-robin victim pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q  <= '0;
            victim_q <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                vpn_q[i]  <= '0;
                asid_q[i] <= '0;
                pfn_q[i]  <= '0;
            end
        end else if (flush_all) begin
            valid_q <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (flush_asid && (asid_q[i] == flush_id)) valid_q[i] <= 1'b0;
            end
            if (fill_keep) begin
                valid_q[victim_q] <= 1'b1;
                vpn_q[victim_q]   <= fill_vpn;
                asid_q[victim_q]  <= fill_asid;
                pfn_q[victim_q]   <= fill_pfn;
                victim_q          <= (victim_q == LAST_IDX) ? '0 : victim_q + 1'b1;
            end
        end
    end

    p_single_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    p_flush_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (valid_q == '0));

endmodule

// File: rtl/xlate_walker.sv
// Single-level page-table fetch engine.
// Does: on start, computes the entry address and issues one memory read,
//       then reports completion with the returned data.
// Assumes: entries are 4 bytes apart; memory returns exactly one response per read.
module xlate_walker
    import xlate_pkg::*;
#(
    parameter int PA_W  = 32,
    parameter int VPN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [VPN_W-1:0] start_vpn,
    input  logic [PA_W-1:0]  pt_base,
    output logic             busy,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [PA_W-1:0]  mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [PA_W-1:0]  mem_rsp_data,
    output logic             done,
    output logic [PA_W-1:0]  pte_data
);
    walk_state_e     state_q;
    logic [PA_W-1:0] addr_q;

    assign busy          = (state_q != W_IDLE);
    assign mem_req_valid = (state_q == W_REQ);
    assign mem_req_addr  = addr_q;
    assign done          = (state_q == W_WAIT) && mem_rsp_valid;
    assign pte_data      = mem_rsp_data;

    // Walk sequencing: idle, issue read, wait for data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= W_IDLE;
            addr_q  <= '0;
        end else begin
            case (state_q)
                W_IDLE: if (start) begin
                    addr_q  <= pt_base + (PA_W'(start_vpn) << 2);
                    state_q <= W_REQ;
                end
                W_REQ:  if (mem_req_ready) state_q <= W_WAIT;
                W_WAIT: if (mem_rsp_valid) state_q <= W_IDLE;
                default: state_q <= W_IDLE;
            endcase
        end
    end

    p_hold_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

endmodule

// File: rtl/page_xlate.sv
// Paged address translator: cache lookup, range check, page-table walk, response.
// Does: one request at a time; hits answer next cycle, misses walk memory.
// Assumes: rsp is consumed without backpressure; pt_base/pt_len steady during a walk.
module page_xlate
    import xlate_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int PAGE_BITS = 12,
    parameter int ASID_W    = 8,
    parameter int ENTRIES   = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic [VA_W-1:0]             req_vaddr,
    input  logic [ASID_W-1:0]           req_asid,
    output logic                        rsp_valid,
    output logic [PA_W-1:0]             rsp_paddr,
    output logic                        rsp_fault,
    output logic [1:0]                  rsp_cause,
    input  logic [PA_W-1:0]             pt_base,
    input  logic [VA_W-PAGE_BITS:0]     pt_len,
    input  logic                        flush_all,
    input  logic                        flush_asid,
    input  logic [ASID_W-1:0]           flush_id,
    output logic                        mem_req_valid,
    input  logic                        mem_req_ready,
    output logic [PA_W-1:0]             mem_req_addr,
    input  logic                        mem_rsp_valid,
    input  logic [PA_W-1:0]             mem_rsp_data
);
    localparam int VPN_W = VA_W - PAGE_BITS;
    localparam int PFN_W = PA_W - PAGE_BITS;

    logic                 accept;
    logic [VPN_W-1:0]     req_vpn;
    logic [PAGE_BITS-1:0] req_off;
    logic                 hit;
    logic [PFN_W-1:0]     hit_pfn;
    logic                 out_of_range;
    logic                 start_walk;
    logic                 walk_busy;
    logic                 walk_done;
    logic [PA_W-1:0]      pte_data;
    logic                 pte_ok;
    logic [PFN_W-1:0]     pte_pfn;
    logic [VPN_W-1:0]     pend_vpn_q;
    logic [PAGE_BITS-1:0] pend_off_q;
    logic [ASID_W-1:0]    pend_asid_q;

    assign req_ready    = !walk_busy;
    assign accept       = req_valid && req_ready;
    assign req_vpn      = req_vaddr[VA_W-1:PAGE_BITS];
    assign req_off      = req_vaddr[PAGE_BITS-1:0];
    assign out_of_range = ({1'b0, req_vpn} >= pt_len);
    assign start_walk   = accept && !hit && !out_of_range;
    assign pte_ok       = walk_done && pte_data[0];
    assign pte_pfn      = pte_data[PA_W-1:PAGE_BITS];

    xlate_tlb #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .PFN_W   (PFN_W),
        .ASID_W  (ASID_W)
    ) u_tlb (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_vpn     (req_vpn),
        .lk_asid    (req_asid),
        .lk_hit     (hit),
        .lk_pfn     (hit_pfn),
        .fill_en    (pte_ok),
        .fill_vpn   (pend_vpn_q),
        .fill_asid  (pend_asid_q),
        .fill_pfn   (pte_pfn),
        .flush_all  (flush_all),
        .flush_asid (flush_asid),
        .flush_id   (flush_id)
    );

    xlate_walker #(
        .PA_W  (PA_W),
        .VPN_W (VPN_W)
    ) u_walker (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start_walk),
        .start_vpn     (req_vpn),
        .pt_base       (pt_base),
        .busy          (walk_busy),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .done          (walk_done),
        .pte_data      (pte_data)
    );

    // Hold the accepted request's fields for use when a walk completes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_vpn_q  <= '0;
            pend_off_q  <= '0;
            pend_asid_q <= '0;
        end else if (accept) begin
            pend_vpn_q  <= req_vpn;
            pend_off_q  <= req_off;
            pend_asid_q <= req_asid;
        end
    end

    // Build the registered response from a hit, a range fault or a finished walk
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_paddr <= '0;
            rsp_fault <= 1'b0;
            rsp_cause <= CAUSE_NONE;
        end else begin
            rsp_valid <= 1'b0;
            if (accept && hit) begin
                rsp_valid <= 1'b1;
                rsp_paddr <= {hit_pfn, req_off};
                rsp_fault <= 1'b0;
                rsp_cause <= CAUSE_NONE;
            end else if (accept && out_of_range) begin
                rsp_valid <= 1'b1;
                rsp_paddr <= '0;
                rsp_fault <= 1'b1;
                rsp_cause <= CAUSE_RANGE;
            end else if (walk_done) begin
                rsp_valid <= 1'b1;
                if (pte_ok) begin
                    rsp_paddr <= {pte_pfn, pend_off_q};
                    rsp_fault <= 1'b0;
                    rsp_cause <= CAUSE_NONE;
                end else begin
                    rsp_paddr <= '0;
                    rsp_fault <= 1'b1;
                    rsp_cause <= CAUSE_INVALID;
                end
            end
        end
    end

    p_resp_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_fault == (rsp_cause != 2'd0)));

    p_fault_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

    p_busy_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);

    p_offset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault && $past(req_valid && req_ready))
            |-> (rsp_paddr[PAGE_BITS-1:0] == $past(req_vaddr[PAGE_BITS-1:0])));

endmodule

// File: tb/page_xlate_bench.sv
// Directed bench for page_xlate: one task per scenario, each checking its results.
module page_xlate_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [7:0]  req_asid = '0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic        rsp_fault;
    logic [1:0]  rsp_cause;
    logic [31:0] pt_base = 32'h0004_0000;
    logic [20:0] pt_len = 21'd32;
    logic        flush_all = 1'b0;
    logic        flush_asid = 1'b0;
    logic [7:0]  flush_id = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    int n_chk = 0;
    int n_bad = 0;
    int mem_reads = 0;
    int mem_lat = 0;
    logic [31:0] last_addr = '0;
    bit finished = 0;

    always #10 clk = ~clk;

    page_xlate u_page_xlate (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_asid(req_asid),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
        .pt_base(pt_base), .pt_len(pt_len),
        .flush_all(flush_all), .flush_asid(flush_asid), .flush_id(flush_id),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    function automatic logic [19:0] pfn_of(int i);
        return 20'h00100 + 20'(i * 3);
    endfunction

    function automatic logic [31:0] pte_of(logic [31:0] addr);
        logic [31:0] d;
        int idx;
        d = addr - pt_base;
        idx = int'(d >> 2);
        if (d[1:0] != 2'b00 || d >= 32'd256) return 32'h0;
        return {pfn_of(idx), 11'b0, ((idx % 5) != 3)};
    endfunction

    // Memory model: accepts a read, answers after mem_lat extra cycles
    bit pend = 0;
    int cnt = 0;
    logic [31:0] pend_addr = '0;
    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        if (pend) begin
            if (cnt == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = pte_of(pend_addr);
                pend = 0;
            end else cnt--;
        end
        if (mem_req_valid && mem_req_ready && !pend && !mem_rsp_valid) begin
            pend = 1; cnt = mem_lat; pend_addr = mem_req_addr;
            last_addr = mem_req_addr; mem_reads++;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic xlate(input int vpn, input logic [11:0] off, input logic [7:0] asid,
                         output logic [31:0] pa, output logic flt, output logic [1:0] cs,
                         output int lat, output int rd, output bit leak);
        int r0;
        r0 = mem_reads;
        leak = 0;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = {20'(vpn), off}; req_asid = asid;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 60) begin
            if (req_ready) leak = 1;
            @(negedge clk);
            lat++;
        end
        pa = rsp_paddr; flt = rsp_fault; cs = rsp_cause;
        rd = mem_reads - r0;
    endtask

    task automatic expect_ok(input int vpn, input logic [11:0] off, input logic [7:0] asid,
                             input int exp_rd, input string tag);
        logic [31:0] pa; logic flt; logic [1:0] cs; int lat; int rd; bit leak;
        xlate(vpn, off, asid, pa, flt, cs, lat, rd, leak);
        chk(pa == {pfn_of(vpn), off} && !flt && cs == 2'd0, {tag, " paddr"}, {flt, cs, pa}, {3'b000, pfn_of(vpn), off});
        chk(rd == exp_rd, {tag, " reads"}, rd, exp_rd);
        if (exp_rd == 0) chk(lat == 1, {tag, " hit latency R2"}, lat, 1);
        else chk(!leak, {tag, " ready low during walk R9"}, leak, 0);
    endtask

    task automatic do_flush_all();
        @(negedge clk); flush_all = 1'b1;
        @(negedge clk); flush_all = 1'b0;
    endtask

    task automatic do_flush_id(input logic [7:0] id);
        @(negedge clk); flush_asid = 1'b1; flush_id = id;
        @(negedge clk); flush_asid = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(req_ready == 1'b1, "reset req_ready", req_ready, 1);
        chk(rsp_valid == 1'b0, "reset rsp_valid", rsp_valid, 0);
        chk(mem_req_valid == 1'b0, "reset mem_req_valid", mem_req_valid, 0);
    endtask

    // R1 R4 R5 then R2: miss walks memory at the right address, repeat hits
    task automatic t_miss_hit();
        expect_ok(1, 12'h234, 8'd3, 1, "R4 R5 miss");
        chk(last_addr == pt_base + 32'd4, "R4 walk address", last_addr, pt_base + 32'd4);
        expect_ok(1, 12'h567, 8'd3, 0, "R2 R1 hit");
    endtask

    // R3: same page under another identifier misses
    task automatic t_asid();
        expect_ok(1, 12'h010, 8'd4, 1, "R3 other identifier");
        expect_ok(1, 12'h020, 8'd4, 0, "R3 second identifier hit");
    endtask

    // R6: page number at or above the table length faults without a read
    task automatic t_range();
        logic [31:0] pa; logic flt; logic [1:0] cs; int lat; int rd; bit leak;
        xlate(32, 12'h001, 8'd3, pa, flt, cs, lat, rd, leak);
        chk(flt && cs == 2'd1, "R6 range fault", {flt, cs}, 3'b101);
        chk(rd == 0, "R6 no read", rd, 0);
        chk(pa == 32'h0, "R8 fault paddr", pa, 0);
        expect_ok(31, 12'h002, 8'd3, 1, "R6 last in-range page");
    endtask

    // R7: invalid entry faults and is not cached
    task automatic t_invalid();
        logic [31:0] pa; logic flt; logic [1:0] cs; int lat; int rd; bit leak;
        xlate(3, 12'h0AB, 8'd3, pa, flt, cs, lat, rd, leak);
        chk(flt && cs == 2'd2 && rd == 1, "R7 invalid entry", {flt, cs, 8'(rd)}, {3'b110, 8'd1});
        xlate(3, 12'h0AB, 8'd3, pa, flt, cs, lat, rd, leak);
        chk(flt && cs == 2'd2 && rd == 1, "R7 not cached", {flt, cs, 8'(rd)}, {3'b110, 8'd1});
    endtask

    // R11: selective flush removes only one identifier
    task automatic t_flush_id();
        do_flush_id(8'd3);
        expect_ok(1, 12'h100, 8'd4, 0, "R11 other identifier kept");
        expect_ok(1, 12'h100, 8'd3, 1, "R11 flushed identifier");
    endtask

    // R10: global flush removes every identifier
    task automatic t_flush_all();
        do_flush_all();
        expect_ok(1, 12'h200, 8'd3, 1, "R10 flushed id3");
        expect_ok(1, 12'h200, 8'd4, 1, "R10 flushed id4");
    endtask

    // R12: ninth fill evicts the oldest, the rest still hit
    task automatic t_round_robin();
        int pages [8] = '{0, 1, 2, 4, 5, 6, 7, 9};
        do_flush_all();
        foreach (pages[k]) expect_ok(pages[k], 12'h040, 8'd1, 1, "R12 fill");
        expect_ok(10, 12'h040, 8'd1, 1, "R12 ninth fill");
        expect_ok(1, 12'h041, 8'd1, 0, "R12 second-oldest kept");
        expect_ok(0, 12'h042, 8'd1, 1, "R12 oldest evicted");
    endtask

    // R1 R9: offset extremes through a slow memory
    task automatic t_slow_offsets();
        mem_lat = 4;
        expect_ok(11, 12'hFFF, 8'd2, 1, "R9 R1 slow walk top offset");
        chk(last_addr == pt_base + 32'd44, "R4 walk address page 11", last_addr, pt_base + 32'd44);
        expect_ok(11, 12'h000, 8'd2, 0, "R1 zero offset");
        mem_lat = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_miss_hit();
        t_asid();
        t_range();
        t_invalid();
        t_flush_id();
        t_flush_all();
        t_round_robin();
        t_slow_offsets();
        repeat (3) @(negedge clk);
        summary();
    end

endmodule